// File: doc/BRIEF.md
# Interlaced Standard-Definition Digital Video Stream Generator

This block turns a stream of 4:2:2 pixel samples into an 8-bit interlaced digital component video stream for 720-pixel standard-definition television. It owns all line and field timing for the 525-line and 625-line standards. It frames every line with in-band timing reference codes: an end-of-active-video code, a horizontal blanking run, a start-of-active-video code and the active samples. It also emits two optional discrete sync strobes for encoders that want them.

Samples are pulled from an upstream queue with a ready/valid handshake. The block asserts its ready output in each active byte slot of each active line. The timing never waits for the source: a slot whose sample is not valid is filled with the blanking level. A standard select input may be changed at any time. The block takes up the new standard only at the next frame boundary.

Line lengths, blanking widths, line counts per field section and strobe lengths are parameters. The defaults give the broadcast values. The horizontal blanking widths must be multiples of four.

Top module: `bt656_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it, `bt_data` is 0x10 and `hsync`, `vsync` and `pix_rdy` are 0. The byte after that is 0xFF, the first byte of line 0 of field 0 in the standard that `pal_sel` selected during reset.
- R2: A line is 4 code bytes, a horizontal blanking run, 4 code bytes and 2×ACT_PIX active bytes. With the defaults this is 1716 clocks for the 525-line standard (268 blanking bytes) and 1728 clocks for the 625-line standard (280 blanking bytes).
- R3: Field 0 (F=0) is N_VB1 vertical blanking lines, N_ACT active lines and N_TAIL blanking lines. Field 1 (F=1) is N_VB2, N_ACT and N_TAIL lines. The defaults are 19/240/3 and 20/240/3, which is 525 lines. The 625-line standard uses 22/288/2 and 23/288/2. F changes only at the first byte of a field.
- R4: Each timing reference is the byte sequence 0xFF, 0x00, 0x00, XY. XY has bit 7 = 1, bit 6 = F, bit 5 = V (1 in blanking lines), bit 4 = H (1 for the code that opens the line, 0 for the one before the active samples), and bits 3..0 = V^H, F^H, F^V, F^V^H.
- R5: Horizontal blanking, and the active-sample slots of blanking lines, carry the repeating pair 0x80, 0x10, starting with 0x80.
- R6: `pix_rdy` is high exactly in the active byte slots of active lines. A byte taken while `pix_rdy` and `pix_vld` are both high appears on `bt_data` one clock later. Its position in the Cb, Y, Cr, Y order is kept.
- R7: In a slot where `pix_rdy` is high and `pix_vld` is low, the output is 0x80 at a chroma position (even offset in the active run) and 0x10 at a luma position. The line timing does not stall.
- R8: `pal_sel` (0 = 525-line, 1 = 625-line) is sampled on the last clock of a frame. A change at any other time has no effect until the next frame starts, so no frame mixes the two standards.
- R9: `hsync` is high for HS_LEN clocks (default 20) at the start of every line. It rises together with the 0xFF of the opening code.
- R10: `vsync` is high for the first VS_LINES lines (default 10) of each field. It starts and ends at a line start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_sel | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| pix_data | input | 8 | Upstream sample, in Cb, Y, Cr, Y order |
| pix_vld | input | 1 | Upstream sample valid |
| pix_rdy | output | 1 | Block takes a sample this clock |
| bt_data | output | 8 | Output video byte stream |
| hsync | output | 1 | Optional line strobe, active high |
| vsync | output | 1 | Optional field strobe, active high |

## Verification
A wrong horizontal count shows up within one line. The bytes after a misplaced 0xFF stop matching the reference, and the spacing between `hsync` rises differs from the expected line length. A wrong field or line counter corrupts the F and V bits of the next code word and shifts `vsync` and `pix_rdy`, so the error is visible at the next line boundary. A standard select that is applied too early changes a line length in the middle of a frame. The length check on the following line catches it.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    typedef enum logic [1:0] {
        SEG_EAV  = 2'd0,
        SEG_HBLK = 2'd1,
        SEG_SAV  = 2'd2,
        SEG_ACT  = 2'd3
    } seg_e;

    typedef struct packed {
        seg_e       seg;
        logic [1:0] ph;
        logic       fld;
        logic       vbl;
        logic       hs;
        logic       vs;
    } tslot_t;

    localparam logic [7:0] CODE_HI = 8'hFF;
    localparam logic [7:0] CODE_LO = 8'h00;
    localparam logic [7:0] FILL_C  = 8'h80;
    localparam logic [7:0] FILL_Y  = 8'h10;

    function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] fill_byte(input logic odd);
        return odd ? FILL_Y : FILL_C;
    endfunction

endpackage

// File: rtl/bt656_timing.sv
module bt656_timing
    import bt656_pkg::*;
#(
    parameter int ACT_PIX  = 720,
    parameter int BLANK_N  = 268,
    parameter int BLANK_P  = 280,
    parameter int N_VB1    = 19,
    parameter int N_VB2    = 20,
    parameter int N_ACT    = 240,
    parameter int N_TAIL   = 3,
    parameter int P_VB1    = 22,
    parameter int P_VB2    = 23,
    parameter int P_ACT    = 288,
    parameter int P_TAIL   = 2,
    parameter int HS_LEN   = 20,
    parameter int VS_LINES = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pal_sel,
    output tslot_t slot_o,
    output logic   pix_rdy
);

    localparam int LINE_N  = 8 + BLANK_N + 2 * ACT_PIX;
    localparam int LINE_P  = 8 + BLANK_P + 2 * ACT_PIX;
    localparam int LINE_MX = (LINE_N > LINE_P) ? LINE_N : LINE_P;
    localparam int FN_MX   = ((N_VB1 > N_VB2) ? N_VB1 : N_VB2) + N_ACT + N_TAIL;
    localparam int FP_MX   = ((P_VB1 > P_VB2) ? P_VB1 : P_VB2) + P_ACT + P_TAIL;
    localparam int FLD_MX  = (FN_MX > FP_MX) ? FN_MX : FP_MX;
    localparam int HW      = $clog2(LINE_MX + 1);
    localparam int VW      = $clog2(FLD_MX + 1);

    logic [HW-1:0] h_q;
    logic [VW-1:0] v_q;
    logic          f_q;
    logic          pal_q;

    logic [HW-1:0] h_last, blank_len;
    logic [VW-1:0] vb_len, act_len, tail_len, fld_last;
    logic          vbl;
    seg_e          seg;

    always_comb begin
        blank_len = pal_q ? HW'(BLANK_P) : HW'(BLANK_N);
        h_last    = pal_q ? HW'(LINE_P - 1) : HW'(LINE_N - 1);
        if (pal_q) begin
            vb_len   = f_q ? VW'(P_VB2) : VW'(P_VB1);
            act_len  = VW'(P_ACT);
            tail_len = VW'(P_TAIL);
        end else begin
            vb_len   = f_q ? VW'(N_VB2) : VW'(N_VB1);
            act_len  = VW'(N_ACT);
            tail_len = VW'(N_TAIL);
        end
        fld_last = vb_len + act_len + tail_len - VW'(1);
        vbl      = (v_q < vb_len) || (v_q >= vb_len + act_len);

        if (h_q < HW'(4))                   seg = SEG_EAV;
        else if (h_q < HW'(4) + blank_len)  seg = SEG_HBLK;
        else if (h_q < HW'(8) + blank_len)  seg = SEG_SAV;
        else                                seg = SEG_ACT;
    end

    assign slot_o.seg = seg;
    assign slot_o.ph  = h_q[1:0];
    assign slot_o.fld = f_q;
    assign slot_o.vbl = vbl;
    assign slot_o.hs  = (h_q < HW'(HS_LEN));
    assign slot_o.vs  = (v_q < VW'(VS_LINES));
    assign pix_rdy    = (seg == SEG_ACT) && !vbl;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q   <= '0;
            v_q   <= '0;
            f_q   <= 1'b0;
            pal_q <= pal_sel;
        end else if (h_q == h_last) begin
            h_q <= '0;
            if (v_q == fld_last) begin
                v_q <= '0;
                f_q <= ~f_q;
                if (f_q) pal_q <= pal_sel;
            end else begin
                v_q <= v_q + VW'(1);
            end
        end else begin
            h_q <= h_q + HW'(1);
        end
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pal_q != $past(pal_q)) |-> (h_q == '0 && v_q == '0 && !f_q));

    // R3
    fld_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (f_q != $past(f_q)) |-> (h_q == '0 && v_q == '0));

    // R2
    h_bound_chk: assert property (@(posedge clk) disable iff (rst)
        h_q <= h_last);

endmodule

// File: rtl/bt656_fmt.sv
module bt656_fmt
    import bt656_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tslot_t     slot_i,
    input  logic [7:0] pix_data,
    input  logic       pix_vld,
    output logic [7:0] bt_data,
    output logic       hsync,
    output logic       vsync
);

    logic [7:0] nxt;

    always_comb begin
        unique case (slot_i.seg)
            SEG_EAV, SEG_SAV: begin
                unique case (slot_i.ph)
                    2'd0:    nxt = CODE_HI;
                    2'd3:    nxt = trs_word(slot_i.fld, slot_i.vbl, slot_i.seg == SEG_EAV);
                    default: nxt = CODE_LO;
                endcase
            end
            SEG_HBLK: nxt = fill_byte(slot_i.ph[0]);
            default: begin
                if (!slot_i.vbl && pix_vld) nxt = pix_data;
                else                        nxt = fill_byte(slot_i.ph[0]);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bt_data <= FILL_Y;
            hsync   <= 1'b0;
            vsync   <= 1'b0;
        end else begin
            bt_data <= nxt;
            hsync   <= slot_i.hs;
            vsync   <= slot_i.vs;
        end
    end

    // R6
    take_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        $past(slot_i.seg == SEG_ACT && !slot_i.vbl && pix_vld) |-> (bt_data == $past(pix_data)));

endmodule

// File: rtl/bt656_gen.sv
module bt656_gen
    import bt656_pkg::*;
#(
    parameter int ACT_PIX  = 720,
    parameter int BLANK_N  = 268,
    parameter int BLANK_P  = 280,
    parameter int N_VB1    = 19,
    parameter int N_VB2    = 20,
    parameter int N_ACT    = 240,
    parameter int N_TAIL   = 3,
    parameter int P_VB1    = 22,
    parameter int P_VB2    = 23,
    parameter int P_ACT    = 288,
    parameter int P_TAIL   = 2,
    parameter int HS_LEN   = 20,
    parameter int VS_LINES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pal_sel,
    input  logic [7:0] pix_data,
    input  logic       pix_vld,
    output logic       pix_rdy,
    output logic [7:0] bt_data,
    output logic       hsync,
    output logic       vsync
);

    tslot_t slot;

    bt656_timing #(
        .ACT_PIX (ACT_PIX), .BLANK_N(BLANK_N), .BLANK_P(BLANK_P),
        .N_VB1   (N_VB1),   .N_VB2  (N_VB2),   .N_ACT  (N_ACT),   .N_TAIL(N_TAIL),
        .P_VB1   (P_VB1),   .P_VB2  (P_VB2),   .P_ACT  (P_ACT),   .P_TAIL(P_TAIL),
        .HS_LEN  (HS_LEN),  .VS_LINES(VS_LINES)
    ) u_timing (
        .clk     (clk),
        .rst     (rst),
        .pal_sel (pal_sel),
        .slot_o  (slot),
        .pix_rdy (pix_rdy)
    );

    bt656_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .slot_i   (slot),
        .pix_data (pix_data),
        .pix_vld  (pix_vld),
        .bt_data  (bt_data),
        .hsync    (hsync),
        .vsync    (vsync)
    );

    // R9
    hs_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (bt_data == CODE_HI));

endmodule

// File: tb/bt656_gen_tb.sv
module bt656_gen_tb;

    localparam int ACT_PIX = 4, BLANK_N = 8, BLANK_P = 12;
    localparam int N_VB1 = 2, N_VB2 = 3, N_ACT = 3, N_TAIL = 1;
    localparam int P_VB1 = 3, P_VB2 = 4, P_ACT = 4, P_TAIL = 1;
    localparam int HS_LEN = 6, VS_LINES = 2;
    localparam int RUN = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pal_sel = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic       pix_vld = 1'b0;
    logic       pix_rdy, hsync, vsync;
    logic [7:0] bt_data;

    always #2 clk = ~clk;

    bt656_gen #(
        .ACT_PIX(ACT_PIX), .BLANK_N(BLANK_N), .BLANK_P(BLANK_P),
        .N_VB1(N_VB1), .N_VB2(N_VB2), .N_ACT(N_ACT), .N_TAIL(N_TAIL),
        .P_VB1(P_VB1), .P_VB2(P_VB2), .P_ACT(P_ACT), .P_TAIL(P_TAIL),
        .HS_LEN(HS_LEN), .VS_LINES(VS_LINES)
    ) u_dut (
        .clk(clk), .rst(rst), .pal_sel(pal_sel), .pix_data(pix_data),
        .pix_vld(pix_vld), .pix_rdy(pix_rdy), .bt_data(bt_data),
        .hsync(hsync), .vsync(vsync)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference state
    int mh, mv, mf, mpal;

    function automatic int blank_of(int p); return p ? BLANK_P : BLANK_N; endfunction
    function automatic int len_of(int p);   return 8 + blank_of(p) + 2 * ACT_PIX; endfunction
    function automatic int vb_of(int p, int f);
        if (p) return f ? P_VB2 : P_VB1;
        return f ? N_VB2 : N_VB1;
    endfunction
    function automatic int act_of(int p);  return p ? P_ACT : N_ACT; endfunction
    function automatic int tail_of(int p); return p ? P_TAIL : N_TAIL; endfunction
    function automatic int xy_of(int f, int v, int h);
        return 128 + f * 64 + v * 32 + h * 16 + (v ^ h) * 8 + (f ^ h) * 4 + (f ^ v) * 2 + (f ^ v ^ h);
    endfunction

    initial begin
        int exp_b, exp_hs, exp_vs, cnt;
        int lq[$];
        bit prev_hs, seen;
        string tag;
        exp_b = 0; exp_hs = 0; exp_vs = 0; cnt = 0; prev_hs = 0; seen = 0; tag = "";

        repeat (3) @(negedge clk);
        chk(bt_data == 8'h10, "R1 reset data", int'(bt_data), 'h10);
        chk(hsync == 1'b0, "R1 reset hsync", int'(hsync), 0);
        chk(vsync == 1'b0, "R1 reset vsync", int'(vsync), 0);
        chk(pix_rdy == 1'b0, "R1 reset rdy", int'(pix_rdy), 0);

        rst = 1'b0;
        mh = 0; mv = 0; mf = 0; mpal = pal_sel;

        for (int i = 0; i < RUN; i++) begin
            int blk, vbl, aoff, rdy_e, fl;
            if (i > 0) begin
                @(negedge clk);
                chk(bt_data == 8'(exp_b), tag, int'(bt_data), exp_b);
                chk(hsync == 1'(exp_hs), "R9 hsync", int'(hsync), exp_hs);
                chk(vsync == 1'(exp_vs), "R10 vsync", int'(vsync), exp_vs);
                cnt++;
                if (hsync && !prev_hs) begin
                    if (seen) begin
                        chk(cnt == lq[0], "R2 R8 line length", cnt, lq[0]);
                        void'(lq.pop_front());
                    end
                    seen = 1;
                    cnt = 0;
                end
                prev_hs = hsync;
            end else begin
                chk(bt_data == 8'h10, "R1 first cycle data", int'(bt_data), 'h10);
            end

            blk  = blank_of(mpal);
            vbl  = (mv < vb_of(mpal, mf)) || (mv >= vb_of(mpal, mf) + act_of(mpal));
            rdy_e = (mh >= 8 + blk) && !vbl;
            chk(pix_rdy == 1'(rdy_e), "R6 ready", int'(pix_rdy), rdy_e);

            // stimulus
            if (i == 400)  pal_sel = 1'b1;
            if (i == 1500) pal_sel = 1'b0;
            if (i == 2300) pal_sel = 1'b1;
            if (i == 2420) pal_sel = 1'b0;
            pix_vld  = ((i % 7) != 3);
            pix_data = 8'((i * 37) + 5);

            // expected next output
            if (mh < 4) begin
                exp_b = (mh == 0) ? 'hFF : (mh == 3) ? xy_of(mf, vbl, 1) : 0;
                tag = (mh == 0) ? (i == 0 ? "R1 first byte" : "R2 R3 line start") : "R4 opening code";
                if (mh == 0) lq.push_back(len_of(mpal));
            end else if (mh < 4 + blk) begin
                exp_b = ((mh - 4) % 2 == 0) ? 'h80 : 'h10;
                tag = "R5 horizontal blank";
            end else if (mh < 8 + blk) begin
                aoff = mh - 4 - blk;
                exp_b = (aoff == 0) ? 'hFF : (aoff == 3) ? xy_of(mf, vbl, 0) : 0;
                tag = "R4 active code";
            end else begin
                aoff = mh - 8 - blk;
                if (!vbl && pix_vld) begin
                    exp_b = int'(pix_data);
                    tag = "R6 sample";
                end else begin
                    exp_b = (aoff % 2 == 0) ? 'h80 : 'h10;
                    tag = vbl ? "R3 R5 blank line" : "R7 underflow fill";
                end
            end
            exp_hs = (mh < HS_LEN);
            exp_vs = (mv < VS_LINES);

            // advance
            fl = vb_of(mpal, mf) + act_of(mpal) + tail_of(mpal);
            mh++;
            if (mh == len_of(mpal)) begin
                mh = 0;
                if (mv == fl - 1) begin
                    mv = 0;
                    if (mf) begin mf = 0; mpal = pal_sel; end
                    else mf = 1;
                end else begin
                    mv++;
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

endmodule